// File: doc/BRIEF.md
# Card Command Issue and Response Capture Front End

This block sits between a 16-bit register bus and a card-side command engine. Software builds a 32-bit command argument from two halfword writes and then writes a command word. The block latches the command and presents it to the card-side engine with a valid/ready handshake. It then collects the response bytes that the engine streams back into eight 16-bit response registers. When the engine marks the end of the response, the block records completion, timeout and card-error conditions in a status register.

The status register is cleared by writing ones to it. It is combined with a 15-bit enable mask to drive a single interrupt line. A reset-style command 0 issued with the init option completes locally and never reaches the card. Two timeout values are held for the rest of the host: an 8-bit command timeout and a 16-bit data timeout.

Top module: `cmd_resp_front`

## Requirements
- R1: The argument low half is read and written at byte address 0x04 and the high half at 0x08. A write to either half leaves the other half unchanged, and `cmd_arg` carries the full 32-bit argument as it stood when the command was accepted.
- R2: A command word written to address 0x00 while no command is pending is accepted. Its fields are the index in bits 5:0, the init option in bit 7, the response type in bits 10:8, busy signalling in bit 11, the command type in bits 13:12 and the direction in bit 15. One cycle after acceptance, `cmd_valid` rises with `cmd_index`, `cmd_rsp_type`, `cmd_kind` and `cmd_dir` taken from those fields. The request holds steady until the cycle in which `cmd_ready` is high.
- R3: An accepted command with index 0 and the init bit set raises no request. It sets only status bit 0 (end of command) on the accepting clock edge.
- R4: Response byte n, counted from 0 in arrival order, is stored in the response register at address 0x40 + 4*(7 - n/2). Even-numbered bytes go to bits 15:8 and odd-numbered bytes to bits 7:0, so bytes 0 and 1 land in the register at 0x5C. A byte strobe that coincides with `rsp_end` is not stored.
- R5: Accepting a command clears all eight response registers. Bytes beyond the sixteenth are dropped.
- R6: The expected response length is 4 bytes for type codes 1 (R1), 3 (R3) and 6 (R6), 16 bytes for code 2 (R2), and 0 for every other code. If fewer bytes than expected arrive before `rsp_end`, completion sets status bits 7 (timeout) and 0 together and no other bit.
- R7: A complete R1 response with busy signalling sets status bits 0 and 2 together. Any other complete response sets bit 0 without bit 2.
- R8: For a complete R1 response, bytes 0 to 3 form a 32-bit card status with byte 0 as the most significant byte. If that value ANDed with the error mask parameter (default 0xFDF80000) is nonzero, status bit 14 is set.
- R9: Writing the status register at 0x10 clears exactly the bits written as 1. A bit set by hardware on the same edge stays set.
- R10: `irq` is high exactly when the status register ANDed with the 15-bit enable mask at 0x14 is nonzero.
- R11: The command-timeout register at 0x18 keeps the low 8 bits of a write and reads 0 in bits 15:8. The data-timeout register at 0x1C keeps all 16 bits.
- R12: A command write that arrives while a command is pending has no effect on the request outputs, the command register or the response registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational on `bus_addr` |
| cmd_valid | output | 1 | Command request to the card engine |
| cmd_ready | input | 1 | Card engine takes the request |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_type | output | 3 | Response type code |
| cmd_kind | output | 2 | Command type field |
| cmd_dir | output | 1 | Data direction field |
| rsp_valid | input | 1 | Response byte strobe |
| rsp_byte | input | 8 | Response byte |
| rsp_end | input | 1 | Response finished (alone, after the last byte) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that a pending request stays stable until it is taken, and that an init command 0 never raises a request. They also check that timeout always comes together with end of command, that the card-error flag appears only after an end-of-response strobe, and that a zero enable mask silences the interrupt. The exact placement of every response byte is shown only by the bench's sweeps over response type, byte count and busy option. The same holds for the clearing of stale response bytes, the filtering of card-status bits through the error mask and the final status value of each command.

// File: rtl/cmd_resp_front.sv
module cmd_resp_front #(
  parameter logic [31:0] R1_ERR_MASK = 32'hFDF8_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [6:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [5:0]  cmd_index,
  output logic [31:0] cmd_arg,
  output logic [2:0]  cmd_rsp_type,
  output logic [1:0]  cmd_kind,
  output logic        cmd_dir,
  input  logic        rsp_valid,
  input  logic [7:0]  rsp_byte,
  input  logic        rsp_end,
  output logic        irq
);
  localparam logic [6:0] A_CMD  = 7'h00;
  localparam logic [6:0] A_ARGL = 7'h04;
  localparam logic [6:0] A_ARGH = 7'h08;
  localparam logic [6:0] A_STAT = 7'h10;
  localparam logic [6:0] A_IE   = 7'h14;
  localparam logic [6:0] A_CTO  = 7'h18;
  localparam logic [6:0] A_DTO  = 7'h1C;
  localparam int         NRSP   = 8;
  localparam int         MAXB   = 2 * NRSP;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t         state;
  logic [31:0] arg, iss_arg;
  logic [15:0] cmd_reg, status, dto;
  logic [14:0] ie;
  logic [7:0]  cto;
  logic [15:0] rsp [NRSP];
  logic [4:0]  cnt;

  logic wr_cmd, accept, is_init0, cap, fin, short_rsp, r1, err;
  logic [4:0]  exp_len;
  logic [2:0]  slot;
  logic [15:0] hw_set, sw_clr;
  logic [31:0] card_stat;

  assign wr_cmd   = bus_wr && bus_addr == A_CMD;
  assign accept   = wr_cmd && state == S_IDLE;
  assign is_init0 = bus_wdata[7] && bus_wdata[5:0] == 6'd0;
  assign cap      = state == S_WAIT && rsp_valid && !rsp_end && cnt < 5'(MAXB);
  assign fin      = state == S_WAIT && rsp_end;
  assign slot     = 3'd7 - cnt[3:1];

  always_comb begin
    case (cmd_reg[10:8])
      3'd1, 3'd3, 3'd6: exp_len = 5'd4;
      3'd2:             exp_len = 5'd16;
      default:          exp_len = 5'd0;
    endcase
  end

  assign short_rsp = cnt < exp_len;
  assign r1        = cmd_reg[10:8] == 3'd1;
  assign card_stat = {rsp[7], rsp[6]};
  assign err       = r1 && !short_rsp && |(card_stat & R1_ERR_MASK);

  always_comb begin
    hw_set = '0;
    if (accept && is_init0) hw_set[0] = 1'b1;
    if (fin) begin
      hw_set[0]  = 1'b1;
      hw_set[7]  = short_rsp;
      hw_set[2]  = r1 && cmd_reg[11] && !short_rsp;
      hw_set[14] = err;
    end
  end

  assign sw_clr = (bus_wr && bus_addr == A_STAT) ? bus_wdata : 16'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      arg     <= '0;
      iss_arg <= '0;
      cmd_reg <= '0;
      status  <= '0;
      ie      <= '0;
      cto     <= '0;
      dto     <= '0;
      cnt     <= '0;
    end else begin
      if (bus_wr && bus_addr == A_ARGL) arg[15:0]  <= bus_wdata;
      if (bus_wr && bus_addr == A_ARGH) arg[31:16] <= bus_wdata;
      if (bus_wr && bus_addr == A_IE)   ie  <= bus_wdata[14:0];
      if (bus_wr && bus_addr == A_CTO)  cto <= bus_wdata[7:0];
      if (bus_wr && bus_addr == A_DTO)  dto <= bus_wdata;
      status <= (status & ~sw_clr) | hw_set;
      if (accept) begin
        cmd_reg <= bus_wdata;
        iss_arg <= arg;
        cnt     <= '0;
      end else if (cap) begin
        cnt <= cnt + 5'd1;
      end
      case (state)
        S_IDLE: if (accept && !is_init0) state <= S_REQ;
        S_REQ:  if (cmd_ready) state <= S_WAIT;
        S_WAIT: if (rsp_end) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NRSP; k++) begin
      if (!rst_n || accept) begin
        rsp[k] <= '0;
      end else if (cap && 3'(k) == slot) begin
        if (cnt[0]) rsp[k][7:0]  <= rsp_byte;
        else        rsp[k][15:8] <= rsp_byte;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CMD:   bus_rdata = cmd_reg;
      A_ARGL:  bus_rdata = arg[15:0];
      A_ARGH:  bus_rdata = arg[31:16];
      A_STAT:  bus_rdata = status;
      A_IE:    bus_rdata = {1'b0, ie};
      A_CTO:   bus_rdata = {8'h00, cto};
      A_DTO:   bus_rdata = dto;
      default: bus_rdata = (bus_addr[6:5] == 2'b10 && bus_addr[1:0] == 2'b00)
                           ? rsp[bus_addr[4:2]] : 16'h0;
    endcase
  end

  assign cmd_valid    = state == S_REQ;
  assign cmd_index    = cmd_reg[5:0];
  assign cmd_rsp_type = cmd_reg[10:8];
  assign cmd_kind     = cmd_reg[13:12];
  assign cmd_dir      = cmd_reg[15];
  assign cmd_arg      = iss_arg;
  assign irq          = |(status[14:0] & ie);
endmodule

// File: rtl/cmd_resp_front_chk.sv
module cmd_resp_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [6:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [5:0]  cmd_index,
  input logic [31:0] cmd_arg,
  input logic        rsp_end,
  input logic        irq,
  input logic [15:0] status
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_index) && $stable(cmd_arg));

  // R3
  init_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h00 && bus_wdata[7] && bus_wdata[5:0] == 6'd0 |=> !$rose(cmd_valid));

  // R6
  timeout_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[7]) |-> status[0]);

  // R8
  card_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[14]) |-> $past(rsp_end));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h14 && bus_wdata[14:0] == 15'd0 |=> !irq);
endmodule

bind cmd_resp_front cmd_resp_front_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_index(cmd_index), .cmd_arg(cmd_arg), .rsp_end(rsp_end),
  .irq(irq), .status(status)
);

// File: tb/cmd_resp_front_tb_top.sv
module cmd_resp_front_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, bus_wr, cmd_ready, rsp_valid, rsp_end;
  logic [6:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        cmd_valid, cmd_dir, irq;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic [2:0]  cmd_rsp_type;
  logic [1:0]  cmd_kind;
  logic [7:0]  rsp_byte;

  cmd_resp_front dut_i (.*);

  localparam logic [31:0] MASK = 32'hFDF8_0000;
  int nvec = 0, nfail = 0;
  logic [7:0]  rb [18];
  logic [31:0] cur_arg;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int exp_len(input int rt);
    if (rt == 1 || rt == 3 || rt == 6) return 4;
    if (rt == 2) return 16;
    return 0;
  endfunction

  task automatic serve(input int nb);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    for (int i = 0; i < nb; i++) begin
      rsp_valid = 1'b1; rsp_byte = rb[i];
      @(negedge clk);
    end
    rsp_valid = 1'b0;
    rsp_end = 1'b1;
    @(negedge clk);
    rsp_end = 1'b0;
  endtask

  task automatic run_cmd(input int idx, input int rt, input bit busy, input int nb);
    logic [15:0] cw, v, es, hi, lo;
    logic [31:0] cs;
    bit sh;
    cw = {1'b0, 2'(idx % 4), busy, 3'(rt), 1'b0, 1'b0, 6'(idx)};
    wr(7'h10, 16'hFFFF);
    wr(7'h00, cw);
    chk("R2 valid", {31'd0, cmd_valid}, 32'd1);
    chk("R2 index", {26'd0, cmd_index}, 32'(idx));
    chk("R2 rtype/kind", {27'd0, cmd_rsp_type, cmd_kind}, {27'd0, 3'(rt), 2'(idx % 4)});
    chk("R1 cmd_arg", cmd_arg, cur_arg);
    serve(nb);
    sh = nb < exp_len(rt);
    cs = {rb[0], rb[1], rb[2], rb[3]};
    if (sh) es = 16'h0081;
    else begin
      es = 16'h0001;
      if (rt == 1 && busy) es |= 16'h0004;
      if (rt == 1 && (cs & MASK) != 0) es |= 16'h4000;
    end
    rd(7'h10, v);
    chk($sformatf("R6 R7 R8 status rt=%0d nb=%0d busy=%0d", rt, nb, busy), {16'd0, v}, {16'd0, es});
    for (int k = 0; k < 8; k++) begin
      hi = (2*k < nb && 2*k < 16) ? {8'd0, rb[2*k]} : 16'd0;
      lo = (2*k+1 < nb && 2*k+1 < 16) ? {8'd0, rb[2*k+1]} : 16'd0;
      rd(7'(7'h40 + 4*(7-k)), v);
      chk($sformatf("R4 R5 rsp slot %0d nb=%0d", 7-k, nb), {16'd0, v}, {16'd0, hi[7:0], lo[7:0]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int seed;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_byte = '0; rsp_end = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(7'h10, v); chk("reset status", {16'd0, v}, 32'd0);
    chk("reset irq R10", {31'd0, irq}, 32'd0);
    chk("reset valid R2", {31'd0, cmd_valid}, 32'd0);
    rd(7'h5C, v); chk("reset rsp R4", {16'd0, v}, 32'd0);

    // R1
    wr(7'h04, 16'h1234); wr(7'h08, 16'hABCD); wr(7'h04, 16'h5678);
    rd(7'h04, v); chk("R1 low", {16'd0, v}, 32'h5678);
    rd(7'h08, v); chk("R1 high", {16'd0, v}, 32'hABCD);
    cur_arg = 32'hABCD_5678;

    // R11
    wr(7'h18, 16'hBEEF); rd(7'h18, v); chk("R11 cto", {16'd0, v}, 32'h00EF);
    wr(7'h1C, 16'hCAFE); rd(7'h1C, v); chk("R11 dto", {16'd0, v}, 32'hCAFE);

    // R3
    wr(7'h10, 16'hFFFF);
    wr(7'h00, 16'h0080);
    chk("R3 no request", {31'd0, cmd_valid}, 32'd0);
    rd(7'h10, v); chk("R3 status", {16'd0, v}, 32'h0001);

    // R10 / R9
    wr(7'h14, 16'h0001);
    chk("R10 irq on", {31'd0, irq}, 32'd1);
    wr(7'h14, 16'h0000);
    chk("R10 irq masked", {31'd0, irq}, 32'd0);
    wr(7'h14, 16'h7FFF);
    wr(7'h10, 16'h0002);
    rd(7'h10, v); chk("R9 clear other bit", {16'd0, v}, 32'h0001);
    wr(7'h10, 16'h0001);
    rd(7'h10, v); chk("R9 cleared", {16'd0, v}, 32'h0000);
    chk("R10 irq off", {31'd0, irq}, 32'd0);

    // R12
    for (int i = 0; i < 18; i++) rb[i] = 8'(8'h30 + i);
    wr(7'h10, 16'hFFFF);
    wr(7'h00, 16'h0211);
    wr(7'h00, 16'h0105);
    chk("R12 index held", {26'd0, cmd_index}, 32'd17);
    rd(7'h00, v); chk("R12 cmd reg", {16'd0, v}, 32'h0211);
    serve(16);
    rd(7'h5C, v); chk("R12 R4 first pair", {16'd0, v}, 32'h3031);

    // R8 specific card status values
    rb[0] = 8'h80; rb[1] = 8'h00; rb[2] = 8'h00; rb[3] = 8'h00;
    run_cmd(13, 1, 1'b0, 4);
    rb[0] = 8'h00; rb[1] = 8'h00; rb[2] = 8'h09; rb[3] = 8'h00;
    run_cmd(13, 1, 1'b1, 4);
    rb[0] = 8'h02; rb[1] = 8'h00; rb[2] = 8'h00; rb[3] = 8'h00;
    run_cmd(7, 1, 1'b0, 4);
    rb[0] = 8'h00; rb[1] = 8'h08; rb[2] = 8'h00; rb[3] = 8'h00;
    run_cmd(7, 1, 1'b0, 4);

    // sweep: R4 R5 R6 R7 R8
    seed = 1;
    foreach (rb[i]) rb[i] = 8'h00;
    for (int rt = 0; rt < 8; rt++) begin
      for (int ni = 0; ni < 6; ni++) begin
        for (int b = 0; b < 2; b++) begin
          int nb;
          case (ni)
            0: nb = 0; 1: nb = 3; 2: nb = 4; 3: nb = 5; 4: nb = 16; default: nb = 18;
          endcase
          for (int i = 0; i < 18; i++) rb[i] = 8'((seed * 37 + i * 29 + 11) & 8'hFF);
          seed++;
          wr(7'h04, 16'(seed * 97));
          cur_arg = {16'hABCD, 16'(seed * 97)};
          run_cmd((rt * 7 + ni + b) % 64, rt, b[0], nb);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule